// File: doc/BRIEF.md
# Ethernet Frame Transmit Builder

This block assembles the header of an outgoing Ethernet II frame and then streams a user payload behind it, one 16-bit word per cycle, onto a transmit-buffer write path. A user module starts a frame by raising a send request. The builder then asks a shared-bus arbiter for access and waits for the grant. It fetches the station's own source address from six byte-wide chip registers and writes the header: destination address, then source address, then the EtherType. After the header it takes payload words for as long as the user keeps the request high.

A frame carries no length field. The user ends the payload by lowering the request. The builder then gives one completion pulse, returns to idle and releases its bus request. The destination address, EtherType and register base index are parameters. The source address is read again for every frame, so a change in the chip registers appears in the next frame.

Top module: `eth_tx_framer`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the outputs bus_req, snd_ready, snd_done, tx_wr and reg_rd_en are all low.
- R2: When snd_req is seen high in idle, bus_req rises on the next cycle. No reg_rd_en and no tx_wr occurs in any cycle in which bus_gnt is low.
- R3: After the grant, the block issues exactly six register reads at indices MAC_BASE (default 0x10) through MAC_BASE+5, in increasing order. Each read is a one-cycle reg_rd_en pulse, and the next read is not issued until reg_rd_valid has returned the previous byte.
- R4: The first three tx_wr words are the destination address DST_MAC (default all ones), most significant 16 bits first.
- R5: The next three tx_wr words hold the source address. Byte k is the byte read at MAC_BASE+k. Word j is {byte 2j in bits 15:8, byte 2j+1 in bits 7:0}.
- R6: The seventh tx_wr word is ETHER_TYPE (default 0x0800), and the payload starts directly after it.
- R7: snd_ready is high only in the payload phase, after the seventh header word. In each cycle with snd_ready and snd_req both high, tx_wr is high and tx_word equals snd_data. When snd_ready is high and snd_req is low, no word is written.
- R8: The payload ends at the first payload-phase cycle in which snd_req is low. If the request has already fallen before the header is finished, the frame carries the full header and zero payload words.
- R9: snd_done is a single-cycle pulse on the cycle after the ending cycle of R8, and bus_req is low on the cycle after snd_done.
- R10: Every frame reads the source address again from the registers, so a new register value appears in the source words of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_req | input | 1 | User send request, held high through the payload |
| snd_data | input | 16 | User payload word |
| snd_ready | output | 1 | High while payload words are accepted |
| snd_done | output | 1 | One-cycle frame completion pulse |
| bus_req | output | 1 | Request to the shared-bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_rd_idx | output | 8 | Register index for the read |
| reg_rd_data | input | 8 | Register read data byte |
| reg_rd_valid | input | 1 | Read data valid strobe |
| tx_wr | output | 1 | Transmit-buffer write strobe |
| tx_word | output | 16 | Transmit-buffer write word |

## Verification
The block's outputs are decoded from registered state. bus_req therefore follows a seen request by one cycle. Payload writes appear in the same cycle as the snd_data they carry, snd_done comes one cycle after the first low-request payload cycle, and bus_req falls one cycle after that. The bench drives inputs at the falling edge and samples three nanoseconds later, so each observation shows the state the next rising edge will act on. A per-cycle monitor checks these one-cycle relations in every cycle. Each scenario task then compares the recorded write and read sequences word by word against values it computes from the register contents and payload it supplied.

// File: rtl/eth_txf_pkg.sv
// Package: shared types and constants for the Ethernet transmit frame builder.
// Assumes 16-bit transmit words and a 48-bit station address.
package eth_txf_pkg;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 48;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ADDR_WORDS = ADDR_W / WORD_W;
    localparam int HDR_WORDS = 2 * ADDR_WORDS + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_FETCH,
        ST_HDR,
        ST_PAY,
        ST_DONE
    } txf_state_e;
endpackage

// File: rtl/eth_txf_mac_fetch.sv
// Module: reads the station source address one byte at a time from chip
// registers at consecutive indices starting at MAC_BASE and holds the
// result. Assumes one read outstanding; reg_rd_valid returns the byte later.
module eth_txf_mac_fetch
    import eth_txf_pkg::*;
#(
    parameter int          IDX_W    = 8,
    parameter logic [7:0]  MAC_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        rd_data,
    input  logic              rd_valid,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] mac,
    output logic              fetch_done
);
    localparam int CNT_W = $clog2(ADDR_BYTES);

    logic             active_q;
    logic             issue_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_byte;

    // purpose: decode the read strobe, the index and the end of the fetch
    always_comb begin
        rd_en      = active_q && issue_q;
        rd_idx     = IDX_W'(MAC_BASE) + IDX_W'(cnt_q);
        last_byte  = (cnt_q == CNT_W'(ADDR_BYTES - 1));
        fetch_done = active_q && !issue_q && rd_valid && last_byte;
    end

    // purpose: sequence the six reads and capture each returned byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            issue_q  <= 1'b0;
            cnt_q    <= '0;
            mac      <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            issue_q  <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (issue_q) begin
                issue_q <= 1'b0;
            end else if (rd_valid) begin
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (cnt_q == CNT_W'(b)) mac[8*(ADDR_BYTES-1-b) +: 8] <= rd_data;
                end
                if (last_byte) begin
                    active_q <= 1'b0;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                    issue_q <= 1'b1;
                end
            end
        end
    end

    // R3: a read strobe never lasts more than one cycle
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R3: read indices stay inside the six-byte window
    p_idx_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_idx >= IDX_W'(MAC_BASE)) && (rd_idx < IDX_W'(MAC_BASE) + IDX_W'(ADDR_BYTES)));
endmodule

// File: rtl/eth_txf_hdr_gen.sv
// Module: selects one 16-bit header word by index: destination words,
// then source words, then the EtherType. Purely combinational.
module eth_txf_hdr_gen
    import eth_txf_pkg::*;
#(
    parameter logic [47:0] DST_MAC    = 48'hFFFF_FFFF_FFFF,
    parameter logic [15:0] ETHER_TYPE = 16'h0800
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] src_mac,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] hdr_tab [HDR_WORDS];

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_WORDS; gi++) begin : g_addr
            assign hdr_tab[gi]              = DST_MAC[ADDR_W-1-WORD_W*gi -: WORD_W];
            assign hdr_tab[ADDR_WORDS + gi] = src_mac[ADDR_W-1-WORD_W*gi -: WORD_W];
        end
    endgenerate
    assign hdr_tab[HDR_WORDS-1] = ETHER_TYPE;

    // purpose: index the header table, guarding out-of-range selects
    always_comb begin
        word = '0;
        for (int i = 0; i < HDR_WORDS; i++) begin
            if (sel == 3'(i)) word = hdr_tab[i];
        end
    end
endmodule

// File: rtl/eth_tx_framer.sv
// Module: top of the transmit frame builder. Handshakes with the user,
// requests the shared bus, fetches the source address, emits the header and
// forwards payload until the request drops, then pulses completion.
// Assumes the arbiter holds the grant while bus_req stays high.
module eth_tx_framer
    import eth_txf_pkg::*;
#(
    parameter logic [47:0] DST_MAC    = 48'hFFFF_FFFF_FFFF,
    parameter logic [15:0] ETHER_TYPE = 16'h0800,
    parameter logic [7:0]  MAC_BASE   = 8'h10,
    parameter int          IDX_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_req,
    input  logic [15:0]       snd_data,
    output logic              snd_ready,
    output logic              snd_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              reg_rd_en,
    output logic [IDX_W-1:0]  reg_rd_idx,
    input  logic [7:0]        reg_rd_data,
    input  logic              reg_rd_valid,
    output logic              tx_wr,
    output logic [15:0]       tx_word
);
    txf_state_e        state_q;
    logic [2:0]        hdr_idx_q;
    logic              fetch_start;
    logic              fetch_done;
    logic [ADDR_W-1:0] src_mac;
    logic [WORD_W-1:0] hdr_word;

    eth_txf_mac_fetch #(.IDX_W(IDX_W), .MAC_BASE(MAC_BASE)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .rd_data    (reg_rd_data),
        .rd_valid   (reg_rd_valid),
        .rd_en      (reg_rd_en),
        .rd_idx     (reg_rd_idx),
        .mac        (src_mac),
        .fetch_done (fetch_done)
    );

    eth_txf_hdr_gen #(.DST_MAC(DST_MAC), .ETHER_TYPE(ETHER_TYPE)) u_hdr (
        .sel     (hdr_idx_q),
        .src_mac (src_mac),
        .word    (hdr_word)
    );

    // purpose: decode user, arbiter and write-path outputs from the state
    always_comb begin
        fetch_start = (state_q == ST_ARB) && bus_gnt;
        bus_req     = (state_q != ST_IDLE);
        snd_ready   = (state_q == ST_PAY);
        snd_done    = (state_q == ST_DONE);
        tx_wr       = (state_q == ST_HDR) || ((state_q == ST_PAY) && snd_req);
        tx_word     = (state_q == ST_HDR) ? hdr_word : snd_data;
    end

    // purpose: frame sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hdr_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (snd_req) state_q <= ST_ARB;
                ST_ARB:   if (bus_gnt) state_q <= ST_FETCH;
                ST_FETCH: if (fetch_done) begin
                    state_q   <= ST_HDR;
                    hdr_idx_q <= '0;
                end
                ST_HDR: begin
                    hdr_idx_q <= hdr_idx_q + 1'b1;
                    if (hdr_idx_q == 3'(HDR_WORDS - 1)) state_q <= ST_PAY;
                end
                ST_PAY:   if (!snd_req) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: bus activity only under a grant
    p_no_access_ungranted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || tx_wr) |-> bus_gnt);
    // R2: a request seen in idle raises bus_req next cycle
    p_req_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && snd_req) |=> bus_req);
    // R7: accepted payload word goes straight to the write path
    p_pay_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ready && snd_req) |-> (tx_wr && tx_word == snd_data));
    // R9: completion follows the ending cycle and lasts one cycle
    p_done_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_ready && !snd_req) |=> snd_done);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snd_done |=> (!snd_done && !bus_req));
    // R3: no register read while words are being written
    p_read_not_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_en && tx_wr));
endmodule

// File: tb/eth_tx_framer_tb_top.sv
module eth_tx_framer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snd_req = 1'b0;
    logic [15:0] snd_data = '0;
    logic        snd_ready, snd_done, bus_req, reg_rd_en, tx_wr;
    logic        bus_gnt = 1'b0;
    logic [7:0]  reg_rd_idx;
    logic [7:0]  reg_rd_data = '0;
    logic        reg_rd_valid = 1'b0;
    logic [15:0] tx_word;

    always #5 clk = ~clk;

    eth_tx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_data(snd_data),
        .snd_ready(snd_ready), .snd_done(snd_done), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .reg_rd_en(reg_rd_en), .reg_rd_idx(reg_rd_idx),
        .reg_rd_data(reg_rd_data), .reg_rd_valid(reg_rd_valid),
        .tx_wr(tx_wr), .tx_word(tx_word)
    );

    int tests = 0;
    int fails = 0;

    // environment settings written only by the scenario tasks
    int         gnt_delay = 0;
    logic [7:0] regfile [256];

    // monitor records written only by the monitor
    logic [15:0] txw [512];
    int          txn = 0;
    logic [7:0]  rdi [256];
    int          rdn = 0;
    int          done_cnt = 0;
    int          e_r2 = 0, e_r7 = 0, e_r9 = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // arbiter model: grant after gnt_delay cycles of request
    int gcnt = 0;
    always @(negedge clk) begin
        if (!bus_req) begin
            gcnt = 0;
            bus_gnt = 1'b0;
        end else if (gcnt >= gnt_delay) begin
            bus_gnt = 1'b1;
        end else begin
            gcnt++;
        end
    end

    // register model: byte returns two cycles after the read strobe
    int         lat = 0;
    logic [7:0] lat_idx = '0;
    always @(negedge clk) begin
        if (lat == 1) begin
            reg_rd_valid = 1'b1;
            reg_rd_data  = regfile[lat_idx];
            lat = 0;
        end else begin
            reg_rd_valid = 1'b0;
            if (lat > 1) lat--;
        end
        if (reg_rd_en) begin
            lat_idx = reg_rd_idx;
            lat = 2;
        end
    end

    // per-cycle monitor, sampled after inputs settle and before the edge
    logic prev_end = 1'b0, prev_done = 1'b0;
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            if (tx_wr && txn < 512) begin txw[txn] = tx_word; txn++; end
            if (reg_rd_en && rdn < 256) begin rdi[rdn] = reg_rd_idx; rdn++; end
            if ((reg_rd_en || tx_wr) && !bus_gnt) e_r2++;            // R2
            if (snd_ready && snd_req && !(tx_wr && tx_word == snd_data)) e_r7++; // R7
            if (snd_ready && !snd_req && tx_wr) e_r7++;              // R7
            if (prev_end != snd_done) e_r9++;                        // R9
            if (prev_done && bus_req) e_r9++;                        // R9
            prev_end  = snd_ready && !snd_req;
            prev_done = snd_done;
            if (snd_done) done_cnt++;
        end
    end

    task automatic load_mac(input logic [7:0] seed);
        for (int i = 0; i < 6; i++) regfile[8'h10 + i] = seed + 8'(i * 17);
    endtask

    // compare the recorded frame against the expected header and payload
    task automatic check_frame(input int tx0, input int rd0, input logic [7:0] seed,
                               input int npay, input logic [15:0] pseed, input string req);
        check(rdn - rd0 == 6, "R3", "read count", 64'(rdn - rd0), 6);
        for (int i = 0; i < 6; i++)
            check(rdi[rd0 + i] == 8'(8'h10 + i), "R3", "read index", rdi[rd0 + i], 64'(8'h10 + i));
        check(txn - tx0 == 7 + npay, req, "word count", 64'(txn - tx0), 64'(7 + npay));
        for (int j = 0; j < 3; j++)
            check(txw[tx0 + j] == 16'hFFFF, "R4", "dest word", txw[tx0 + j], 16'hFFFF);
        for (int j = 0; j < 3; j++) begin
            logic [15:0] e;
            e = {8'(seed + 8'(2 * j * 17)), 8'(seed + 8'((2 * j + 1) * 17))};
            check(txw[tx0 + 3 + j] == e, "R5 R10", "source word", txw[tx0 + 3 + j], e);
        end
        check(txw[tx0 + 6] == 16'h0800, "R6", "ethertype", txw[tx0 + 6], 16'h0800);
        for (int k = 0; k < npay; k++) begin
            logic [15:0] e;
            e = pseed + 16'(k * 16'h0101);
            check(txw[tx0 + 7 + k] == e, "R7", "payload word", txw[tx0 + 7 + k], e);
        end
    endtask

    // send one frame; drop_early lowers the request before the header ends
    task automatic send_frame(input int npay, input logic [15:0] pseed, input bit drop_early);
        int k = 0;
        int guard = 0;
        int d0 = done_cnt;
        @(negedge clk);
        snd_req = 1'b1;
        #1;
        check(!bus_req, "R2", "bus_req before seen", 64'(bus_req), 0);
        @(negedge clk);
        #1;
        check(bus_req, "R2", "bus_req after request", 64'(bus_req), 1);
        if (drop_early) snd_req = 1'b0;
        forever begin
            @(negedge clk);
            guard++;
            if (guard > 200) break;
            if (snd_ready) begin
                if (k < npay && snd_req) begin
                    snd_data = pseed + 16'(k * 16'h0101);
                    k++;
                end else begin
                    snd_req = 1'b0;
                    break;
                end
            end
        end
        guard = 0;
        while (done_cnt == d0 && guard < 10) begin @(negedge clk); guard++; end
        @(negedge clk);
        #4;
        check(done_cnt == d0 + 1, "R9", "done pulses", 64'(done_cnt - d0), 1);
        check(!bus_req, "R9", "bus_req released", 64'(bus_req), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        check(!(bus_req || snd_ready || snd_done || tx_wr || reg_rd_en), "R1", "outputs in reset",
              {bus_req, snd_ready, snd_done, tx_wr, reg_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!(bus_req || snd_ready || snd_done || tx_wr || reg_rd_en), "R1", "outputs after reset",
              {bus_req, snd_ready, snd_done, tx_wr, reg_rd_en}, 0);
    endtask

    task automatic t_basic();
        int tx0 = txn, rd0 = rdn;
        gnt_delay = 2;
        load_mac(8'h02);
        send_frame(4, 16'hA000, 1'b0);
        check_frame(tx0, rd0, 8'h02, 4, 16'hA000, "R7");
    endtask

    task automatic t_long_grant();
        int tx0 = txn, rd0 = rdn;
        gnt_delay = 12;
        load_mac(8'h40);
        send_frame(9, 16'h1234, 1'b0);
        check_frame(tx0, rd0, 8'h40, 9, 16'h1234, "R2");
    endtask

    task automatic t_empty_payload();
        int tx0 = txn, rd0 = rdn;
        gnt_delay = 0;
        load_mac(8'h90);
        send_frame(0, 16'h0, 1'b1);
        check_frame(tx0, rd0, 8'h90, 0, 16'h0, "R8");
    endtask

    task automatic t_refetch();
        int tx0 = txn, rd0 = rdn;
        gnt_delay = 1;
        load_mac(8'hC3);
        send_frame(1, 16'h5A5A, 1'b0);
        check_frame(tx0, rd0, 8'hC3, 1, 16'h5A5A, "R10");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) regfile[i] = 8'(i);
        t_reset();
        t_basic();
        t_long_grant();
        t_empty_payload();
        t_refetch();
        repeat (3) @(negedge clk);
        check(e_r2 == 0, "R2", "ungranted accesses", 64'(e_r2), 0);
        check(e_r7 == 0, "R7", "payload handshake errors", 64'(e_r7), 0);
        check(e_r9 == 0, "R9", "completion timing errors", 64'(e_r9), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule